// File: doc/BRIEF.md
# Parallel port mode control register

This block sits on the host side of a bidirectional parallel port and holds the port's operating mode and data direction. A 3-bit mode field and a direction bit are written through a small register bus. From them the block derives every static control the rest of the port needs:
- the FIFO reset;
- the control-line driver style (open-collector or push-pull);
- the output enable of the data lines;
- the source that data-register reads return;
- the enables for the transfer engines that live outside this block.

Two configuration registers are reachable only while the configuration mode is selected. Configuration register B carries the interrupt and DMA channel selections, which the block decodes into line and channel numbers.

The mode register is modelled as a state machine whose states are the eight mode encodings:

| State | Code |
|---|---|
| M_STD | 000 |
| M_BYTE | 001 |
| M_FIFO | 010 |
| M_ECP | 011 |
| M_EPP | 100 |
| M_RSVD | 101 |
| M_TEST | 110 |
| M_CFG | 111 |

There is one transition, T_WR. A bus write to the mode offset moves the machine to the encoding held in write-data bits 7:5 and loads the direction from bit 4. With no such write the machine holds. Reset enters M_STD with direction 0.

Register offsets:

| Offset | Register |
|---|---|
| 0x000 | Data |
| 0x002 | Mode/status |
| 0x003 | FIFO data |
| 0x400 | Configuration A |
| 0x401 | Configuration B |

Top module: `pport_mode_ctl`

## Requirements
- R1: After reset the mode is 000 and the direction is 0. Configuration registers A and B are 0, irq_line is 0 and dma_chan is 0.
- R2: In mode 000, fifo_rst and ctl_open_drain are 1, and data_oe is 1 whatever the direction bit.
- R3: In mode 001, data_oe equals the inverse of the direction bit. A read of offset 0x000 returns pin_data.
- R4: In every mode other than 000, fifo_rst and ctl_open_drain are 0.
- R5: fifo_xfer_en is 1 only in mode 010, and ecp_en is 1 only in mode 011. epp_en is 1 only in mode 100 with epp_support at 1. At most one of the three is 1.
- R6: In mode 110, a write to offset 0x003 pulses fifo_push in the same cycle with fifo_wdata equal to wdata. A read of 0x003 with rd_en pulses fifo_pop and returns fifo_rdata. No engine enable is 1. fifo_push is 0 in modes 000 and 001.
- R7: Mode 101 is stored and reads back as 101. In that mode data_oe is 0, ctl_open_drain is 0, and no engine enable is 1.
- R8: Outside mode 111, reads of 0x400 and 0x401 return 0 and writes to them change nothing. In mode 111 they read back the last value written.
- R9: Configuration register B bits 5:3 select the interrupt line, output on irq_line:

| Code | Line |
|---|---|
| 001 | 7 |
| 010 | 9 |
| 011 | 10 |
| 100 | 11 |
| 101 | 14 |
| 110 | 15 |
| 111 | 5 |
| 000 | 0 |

  Bits 2:0 select the DMA channel, output on dma_chan: 001→1, 010→2, 011→3. Every other code gives 0.
- R10: A read of offset 0x002 returns the mode in bits 7:5 and the direction in bit 4. Bit 0 reads 1 when fifo_empty is 1 (FIFO holds no byte) and 0 otherwise. Bits 3:1 read 0.
- R11: Writes to offset 0x000 set data_out. In every mode but 001, a read of 0x000 returns that stored byte.
- R12: In modes 010, 011, 100, 110 and 111, data_oe equals the inverse of the direction bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 11 | Register offset |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (used only for FIFO pop) |
| rdata | output | 8 | Read data, combinational from addr |
| pin_data | input | 8 | Sampled data-line values |
| data_out | output | 8 | Byte driven onto the data lines |
| fifo_empty | input | 1 | FIFO holds no byte |
| fifo_rdata | input | 8 | FIFO head byte |
| fifo_push | output | 1 | FIFO write strobe |
| fifo_pop | output | 1 | FIFO read strobe |
| fifo_wdata | output | 8 | Byte to push |
| fifo_rst | output | 1 | Hold FIFO in reset |
| ctl_open_drain | output | 1 | Control lines use open-collector drive |
| data_oe | output | 1 | Data-line output enable |
| fifo_xfer_en | output | 1 | Enable FIFO-fed standard transfer engine |
| ecp_en | output | 1 | Enable ECP engine |
| epp_en | output | 1 | Enable EPP engine |
| epp_support | input | 1 | EPP permitted by configuration |
| irq_line | output | 4 | Decoded interrupt line number |
| dma_chan | output | 2 | Decoded DMA channel |

## Verification
The assertions check on every cycle that the drive style and FIFO reset follow the mode, and that the reserved mode leaves the data lines undriven. They also check that the engine enables stay mutually exclusive, that EPP never runs without epp_support, and that hidden writes to configuration B leave the decoded outputs stable. The bench sweeps every mode against both directions and both epp_support values, and sweeps all 64 values of configuration register B. Only those scenarios show readback sources, hidden-window reads, FIFO strobes in test mode and the exact decode tables.

// File: rtl/pport_pkg.sv
package pport_pkg;

    typedef enum logic [2:0] {
        M_STD  = 3'd0,
        M_BYTE = 3'd1,
        M_FIFO = 3'd2,
        M_ECP  = 3'd3,
        M_EPP  = 3'd4,
        M_RSVD = 3'd5,
        M_TEST = 3'd6,
        M_CFG  = 3'd7
    } pmode_e;

    localparam int IRQ_SEL_LSB = 3;
    localparam int DMA_SEL_LSB = 0;
    localparam int SEL_W       = 3;

endpackage

// File: rtl/pport_mode_fsm.sv
module pport_mode_fsm
    import pport_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_wr,
    input  logic [2:0] mode_wdata,
    input  logic       dir_wdata,
    input  logic       epp_support,
    output pmode_e     mode,
    output logic       dir,
    output logic       fifo_rst,
    output logic       ctl_open_drain,
    output logic       data_oe,
    output logic       pin_readback,
    output logic       cfg_visible,
    output logic       host_fifo_wr,
    output logic       fifo_test,
    output logic       fifo_xfer_en,
    output logic       ecp_en,
    output logic       epp_en
);

    // State register: transition T_WR on a mode write, otherwise hold.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode <= M_STD;
            dir  <= 1'b0;
        end else if (mode_wr) begin
            mode <= pmode_e'(mode_wdata);
            dir  <= dir_wdata;
        end
    end

    // Output decode per state.
    always_comb begin
        fifo_rst       = 1'b0;
        ctl_open_drain = 1'b0;
        data_oe        = ~dir;
        pin_readback   = 1'b0;
        cfg_visible    = 1'b0;
        host_fifo_wr   = 1'b0;
        fifo_test      = 1'b0;
        fifo_xfer_en   = 1'b0;
        ecp_en         = 1'b0;
        epp_en         = 1'b0;
        unique case (mode)
            M_STD: begin
                fifo_rst       = 1'b1;
                ctl_open_drain = 1'b1;
                data_oe        = 1'b1;
            end
            M_BYTE: begin
                pin_readback = 1'b1;
            end
            M_FIFO: begin
                host_fifo_wr = 1'b1;
                fifo_xfer_en = 1'b1;
            end
            M_ECP: begin
                host_fifo_wr = 1'b1;
                ecp_en       = 1'b1;
            end
            M_EPP: begin
                epp_en = epp_support;
            end
            M_RSVD: begin
                data_oe = 1'b0;
            end
            M_TEST: begin
                host_fifo_wr = 1'b1;
                fifo_test    = 1'b1;
            end
            M_CFG: begin
                cfg_visible = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/pport_cfg_regs.sv
module pport_cfg_regs
    import pport_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_a,
    input  logic              wr_b,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] cfg_a,
    output logic [DATA_W-1:0] cfg_b,
    output logic [3:0]        irq_line,
    output logic [1:0]        dma_chan
);

    logic [SEL_W-1:0] irq_sel;
    logic [SEL_W-1:0] dma_sel;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_a <= '0;
            cfg_b <= '0;
        end else begin
            if (wr_a) cfg_a <= wdata;
            if (wr_b) cfg_b <= wdata;
        end
    end

    assign irq_sel = cfg_b[IRQ_SEL_LSB +: SEL_W];
    assign dma_sel = cfg_b[DMA_SEL_LSB +: SEL_W];

    always_comb begin
        unique case (irq_sel)
            3'd1:    irq_line = 4'd7;
            3'd2:    irq_line = 4'd9;
            3'd3:    irq_line = 4'd10;
            3'd4:    irq_line = 4'd11;
            3'd5:    irq_line = 4'd14;
            3'd6:    irq_line = 4'd15;
            3'd7:    irq_line = 4'd5;
            default: irq_line = 4'd0;
        endcase
    end

    always_comb begin
        unique case (dma_sel)
            3'd1:    dma_chan = 2'd1;
            3'd2:    dma_chan = 2'd2;
            3'd3:    dma_chan = 2'd3;
            default: dma_chan = 2'd0;
        endcase
    end

endmodule

// File: rtl/pport_mode_ctl.sv
module pport_mode_ctl
    import pport_pkg::*;
#(
    parameter int              ADDR_W   = 11,
    parameter int              DATA_W   = 8,
    parameter logic [ADDR_W-1:0] DATA_OFS = 11'h000,
    parameter logic [ADDR_W-1:0] MODE_OFS = 11'h002,
    parameter logic [ADDR_W-1:0] FIFO_OFS = 11'h003,
    parameter logic [ADDR_W-1:0] CFGA_OFS = 11'h400,
    parameter logic [ADDR_W-1:0] CFGB_OFS = 11'h401
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rdata,
    input  logic [DATA_W-1:0] pin_data,
    output logic [DATA_W-1:0] data_out,
    input  logic              fifo_empty,
    input  logic [DATA_W-1:0] fifo_rdata,
    output logic              fifo_push,
    output logic              fifo_pop,
    output logic [DATA_W-1:0] fifo_wdata,
    output logic              fifo_rst,
    output logic              ctl_open_drain,
    output logic              data_oe,
    output logic              fifo_xfer_en,
    output logic              ecp_en,
    output logic              epp_en,
    input  logic              epp_support,
    output logic [3:0]        irq_line,
    output logic [1:0]        dma_chan
);

    localparam int MODE_LO = DATA_W - 3;
    localparam int DIR_BIT = DATA_W - 4;

    pmode_e            mode;
    logic [2:0]        cur_mode;
    logic              dir_q;
    logic              pin_readback;
    logic              cfg_visible;
    logic              host_fifo_wr;
    logic              fifo_test;
    logic [DATA_W-1:0] cfg_a;
    logic [DATA_W-1:0] cfg_b;
    logic [DATA_W-1:0] data_q;
    logic [DATA_W-1:0] mode_rd;

    pport_mode_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .mode_wr        (wr_en && addr == MODE_OFS),
        .mode_wdata     (wdata[MODE_LO +: 3]),
        .dir_wdata      (wdata[DIR_BIT]),
        .epp_support    (epp_support),
        .mode           (mode),
        .dir            (dir_q),
        .fifo_rst       (fifo_rst),
        .ctl_open_drain (ctl_open_drain),
        .data_oe        (data_oe),
        .pin_readback   (pin_readback),
        .cfg_visible    (cfg_visible),
        .host_fifo_wr   (host_fifo_wr),
        .fifo_test      (fifo_test),
        .fifo_xfer_en   (fifo_xfer_en),
        .ecp_en         (ecp_en),
        .epp_en         (epp_en)
    );

    assign cur_mode = mode;

    pport_cfg_regs #(.DATA_W(DATA_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_a     (wr_en && cfg_visible && addr == CFGA_OFS),
        .wr_b     (wr_en && cfg_visible && addr == CFGB_OFS),
        .wdata    (wdata),
        .cfg_a    (cfg_a),
        .cfg_b    (cfg_b),
        .irq_line (irq_line),
        .dma_chan (dma_chan)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                             data_q <= '0;
        else if (wr_en && addr == DATA_OFS)     data_q <= wdata;
    end

    assign data_out   = data_q;
    assign fifo_wdata = wdata;
    assign fifo_push  = wr_en && host_fifo_wr && addr == FIFO_OFS;
    assign fifo_pop   = rd_en && fifo_test && addr == FIFO_OFS;

    always_comb begin
        mode_rd                  = '0;
        mode_rd[MODE_LO +: 3]    = cur_mode;
        mode_rd[DIR_BIT]         = dir_q;
        mode_rd[0]               = fifo_empty;
    end

    always_comb begin
        rdata = '0;
        if (addr == DATA_OFS)                      rdata = pin_readback ? pin_data : data_q;
        else if (addr == MODE_OFS)                 rdata = mode_rd;
        else if (addr == FIFO_OFS && fifo_test)    rdata = fifo_rdata;
        else if (addr == CFGA_OFS && cfg_visible)  rdata = cfg_a;
        else if (addr == CFGB_OFS && cfg_visible)  rdata = cfg_b;
    end

endmodule

// File: rtl/pport_mode_ctl_chk.sv
module pport_mode_ctl_chk #(
    parameter int                ADDR_W   = 11,
    parameter logic [ADDR_W-1:0] CFGB_OFS = 11'h401
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        cur_mode,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic              fifo_rst,
    input logic              ctl_open_drain,
    input logic              data_oe,
    input logic              fifo_xfer_en,
    input logic              ecp_en,
    input logic              epp_en,
    input logic              epp_support,
    input logic [3:0]        irq_line,
    input logic [1:0]        dma_chan
);

    // R2
    std_mode_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode == 3'd0) |-> (fifo_rst && ctl_open_drain && data_oe));

    // R4
    push_pull_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode != 3'd0) |-> (!fifo_rst && !ctl_open_drain));

    // R5
    engine_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fifo_xfer_en, ecp_en, epp_en}));

    // R5
    epp_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        epp_en |-> (epp_support && cur_mode == 3'd4));

    // R7
    rsvd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode == 3'd5) |-> (!data_oe && !fifo_xfer_en && !ecp_en && !epp_en));

    // R8
    hidden_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == CFGB_OFS && cur_mode != 3'd7)
            |=> ($stable(irq_line) && $stable(dma_chan)));

endmodule

bind pport_mode_ctl pport_mode_ctl_chk #(.ADDR_W(ADDR_W), .CFGB_OFS(CFGB_OFS)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cur_mode       (cur_mode),
    .wr_en          (wr_en),
    .addr           (addr),
    .fifo_rst       (fifo_rst),
    .ctl_open_drain (ctl_open_drain),
    .data_oe        (data_oe),
    .fifo_xfer_en   (fifo_xfer_en),
    .ecp_en         (ecp_en),
    .epp_en         (epp_en),
    .epp_support    (epp_support),
    .irq_line       (irq_line),
    .dma_chan       (dma_chan)
);

// File: tb/pport_mode_ctl_bench.sv
module pport_mode_ctl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  rdata;
    logic [7:0]  pin_data = '0;
    logic [7:0]  data_out;
    logic        fifo_empty = 1'b1;
    logic [7:0]  fifo_rdata = '0;
    logic        fifo_push, fifo_pop;
    logic [7:0]  fifo_wdata;
    logic        fifo_rst, ctl_open_drain, data_oe;
    logic        fifo_xfer_en, ecp_en, epp_en;
    logic        epp_support = 1'b0;
    logic [3:0]  irq_line;
    logic [1:0]  dma_chan;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    pport_mode_ctl u_pport_mode_ctl (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
        .rd_en(rd_en), .rdata(rdata), .pin_data(pin_data), .data_out(data_out),
        .fifo_empty(fifo_empty), .fifo_rdata(fifo_rdata), .fifo_push(fifo_push),
        .fifo_pop(fifo_pop), .fifo_wdata(fifo_wdata), .fifo_rst(fifo_rst),
        .ctl_open_drain(ctl_open_drain), .data_oe(data_oe),
        .fifo_xfer_en(fifo_xfer_en), .ecp_en(ecp_en), .epp_en(epp_en),
        .epp_support(epp_support), .irq_line(irq_line), .dma_chan(dma_chan)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [10:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_mode(input int m, input int d);
        wr(11'h002, 8'((m << 5) | (d << 4)));
    endtask

    task automatic rd(input logic [10:0] a, output logic [7:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    function automatic logic [3:0] exp_irq(input int c);
        case (c)
            1: return 4'd7;  2: return 4'd9;  3: return 4'd10; 4: return 4'd11;
            5: return 4'd14; 6: return 4'd15; 7: return 4'd5;
            default: return 4'd0;
        endcase
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : main
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(11'h002, v);
        chk("R1 mode/dir", 32'(v[7:4]), 32'h0);
        chk("R1 irq", 32'(irq_line), 0);
        chk("R1 dma", 32'(dma_chan), 0);
        chk("R1 fifo_rst", 32'(fifo_rst), 1);

        // Load configuration A in mode 111
        set_mode(7, 0);
        wr(11'h400, 8'h5A);

        // Full sweep: mode x direction x epp_support
        for (int m = 0; m < 8; m++) begin
            for (int d = 0; d < 2; d++) begin
                for (int e = 0; e < 2; e++) begin
                    epp_support = e[0];
                    set_mode(m, d);
                    #1;
                    if (m == 0) begin
                        chk("R2 fifo_rst", 32'(fifo_rst), 1);
                        chk("R2 open_drain", 32'(ctl_open_drain), 1);
                        chk("R2 data_oe", 32'(data_oe), 1);
                    end else begin
                        chk("R4 fifo_rst", 32'(fifo_rst), 0);
                        chk("R4 open_drain", 32'(ctl_open_drain), 0);
                        if (m == 1)      chk("R3 data_oe", 32'(data_oe), 32'(1 - d));
                        else if (m == 5) chk("R7 data_oe", 32'(data_oe), 0);
                        else             chk("R12 data_oe", 32'(data_oe), 32'(1 - d));
                    end
                    chk("R5 fifo_xfer_en", 32'(fifo_xfer_en), 32'(m == 2));
                    chk("R5 ecp_en", 32'(ecp_en), 32'(m == 3));
                    chk("R5 epp_en", 32'(epp_en), 32'(m == 4 && e == 1));
                    fifo_empty = e[0];
                    rd(11'h002, v);
                    chk("R10 mode reg", 32'(v), 32'((m << 5) | (d << 4) | e));
                    chk(m == 5 ? "R7 stored" : "R10 stored", 32'(v[7:5]), 32'(m));
                    rd(11'h400, v);
                    chk("R8 cfgA read", 32'(v), (m == 7) ? 32'h5A : 32'h0);
                end
            end
        end

        // R9 sweep over configuration B
        set_mode(7, 0);
        for (int c = 0; c < 64; c++) begin
            wr(11'h401, 8'(c));
            #1;
            chk("R9 irq_line", 32'(irq_line), 32'(exp_irq(c >> 3)));
            chk("R9 dma_chan", 32'(dma_chan), ((c & 7) >= 1 && (c & 7) <= 3) ? 32'(c & 7) : 32'h0);
            rd(11'h401, v);
            chk("R8 cfgB readback", 32'(v), 32'(c));
        end

        // R8 hidden writes ignored
        wr(11'h401, 8'h0A);                 // irq code 001 -> 7, dma 010 -> 2
        set_mode(2, 0);
        wr(11'h401, 8'h33);
        wr(11'h400, 8'hFF);
        #1;
        chk("R8 irq kept", 32'(irq_line), 7);
        chk("R8 dma kept", 32'(dma_chan), 2);
        rd(11'h401, v);
        chk("R8 hidden read", 32'(v), 0);
        set_mode(7, 0);
        rd(11'h401, v);
        chk("R8 cfgB unchanged", 32'(v), 32'h0A);
        rd(11'h400, v);
        chk("R8 cfgA unchanged", 32'(v), 32'h5A);

        // R11 and R3 data register readback
        set_mode(0, 0);
        wr(11'h000, 8'hA5);
        pin_data = 8'h3C;
        rd(11'h000, v);
        chk("R11 data read", 32'(v), 32'hA5);
        chk("R11 data_out", 32'(data_out), 32'hA5);
        set_mode(1, 1);
        rd(11'h000, v);
        chk("R3 pin read", 32'(v), 32'h3C);
        set_mode(3, 0);
        rd(11'h000, v);
        chk("R11 data read ecp", 32'(v), 32'hA5);

        // R6 test mode FIFO access
        set_mode(6, 0);
        @(negedge clk);
        addr = 11'h003; wdata = 8'h77; wr_en = 1'b1;
        #1;
        chk("R6 push", 32'(fifo_push), 1);
        chk("R6 push data", 32'(fifo_wdata), 32'h77);
        chk("R6 no engine", 32'({fifo_xfer_en, ecp_en, epp_en}), 0);
        @(negedge clk);
        wr_en = 1'b0;
        fifo_rdata = 8'hC3; rd_en = 1'b1;
        rd(11'h003, v);
        chk("R6 pop", 32'(fifo_pop), 1);
        chk("R6 pop data", 32'(v), 32'hC3);
        @(negedge clk);
        rd_en = 1'b0;
        set_mode(0, 0);
        @(negedge clk);
        addr = 11'h003; wr_en = 1'b1;
        #1;
        chk("R6 no push in 000", 32'(fifo_push), 0);
        @(negedge clk);
        wr_en = 1'b0;
        set_mode(1, 0);
        @(negedge clk);
        addr = 11'h003; wr_en = 1'b1;
        #1;
        chk("R6 no push in 001", 32'(fifo_push), 0);
        @(negedge clk);
        wr_en = 1'b0;

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule